// File: doc/BRIEF.md
# Bit-Serial Fixed Left Rotator

This block rotates each word of a bit-serial stream left by a fixed amount (three places by default). Words of `WORD_W` bits arrive one bit per accepted clock, least significant bit first. A marker on the first bit of each word tells the block where word boundaries fall. The rotated word leaves on a serial output with its own start marker, a fixed number of accepted clocks later. The rotation uses no barrel shifter. Every accepted bit enters a `WORD_W`-stage delay line. A two-input output mux then picks, for each output bit, either the bit that is arriving right now or the bit that left the delay line.

A phase counter follows the position inside the current word. A start marker forces the phase to zero. Without a new marker, the phase wraps every `WORD_W` accepted bits, so back-to-back words need a marker only to set or correct the alignment. Output bit k is the input bit at (k − ROT) mod `WORD_W`. The output word therefore begins `WORD_W − ROT` accepted clocks after the input word. Its lowest `ROT` bits come straight from the input (bypass), and the remaining bits come from the delay line. `in_valid` acts as a clock enable for the whole block, so gaps in the stream stretch the timing without changing any result.

Top module: `serial_rotl_fixed`

## Requirements
- R1: `out_start` pulses on the accepted clock that lies exactly `WORD_W − ROT` (29 by default) accepted clocks after an accepted `in_start`, provided no further `in_start` is accepted in between.
- R2: Output bits 0 to ROT−1 of a word (LSB-first, counted from the `out_start` clock) equal input bits `WORD_W − ROT` to `WORD_W − 1` of the same input word.
- R3: Output bits ROT to `WORD_W − 1` equal input bits 0 to `WORD_W − ROT − 1` of the same input word, which arrived `WORD_W` accepted clocks earlier.
- R4: Words sent back to back with no idle clock are each rotated correctly, and each produces exactly one `out_start` pulse.
- R5: While `in_valid` is low, the block's state is frozen, `out_start` stays low and `in_start` is ignored. Timing in R1 to R3 is counted in accepted clocks only.
- R6: An `in_start` accepted partway through a word realigns the phase to zero. The cut-short word then produces no `out_start`, and the new word is rotated correctly.
- R7: `out_start` is low while `rst_n` is low and after reset until the first `in_start` has been accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Input bit accepted this clock; enables all state |
| in_start | input | 1 | Marks the first (LSB) bit of an input word |
| in_bit | input | 1 | Serial input data, LSB first |
| out_bit | output | 1 | Serial rotated data, LSB first |
| out_start | output | 1 | Marks the first (LSB) bit of a rotated output word |

## Verification
The bench builds the block with its default parameters, `WORD_W = 32` and `ROT = 3`. It sends a walking-one word for every bit position. Because the datapath only routes bits, this shows where each input bit lands in the output. Random words follow, with random idle gaps during which `in_start` is held high, which exercises the freeze and ignore behaviour. A word cut short by an early start marker checks the realignment and the suppressed marker. Junk bits sent before the first marker check that no `out_start` appears before the block is aligned.

// File: rtl/serial_rot_pkg.sv
package serial_rot_pkg;

  typedef enum logic {
    SEL_DELAY  = 1'b0,
    SEL_BYPASS = 1'b1
  } rot_sel_e;

endpackage

// File: rtl/rot_phase_ctr.sv
module rot_phase_ctr
  import serial_rot_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ROT    = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     start,
  output rot_sel_e sel,
  output logic     word_mark,
  output logic     locked
);

  localparam int PW = $clog2(WORD_W);
  localparam logic [PW-1:0] LAST_PH = PW'(WORD_W - 1);
  localparam logic [PW-1:0] LAT_PH  = PW'(WORD_W - ROT);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          locked_q, locked_d;
  logic [PW-1:0] phase;

  // position of the bit presented this clock
  always_comb begin
    phase = (en && start) ? '0 : cnt_q;
  end

  always_comb begin
    cnt_d    = cnt_q;
    locked_d = locked_q;
    if (en) begin
      cnt_d    = (phase == LAST_PH) ? '0 : phase + 1'b1;
      locked_d = locked_q | start;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      locked_q <= locked_d;
    end
  end

  always_comb begin
    sel       = (phase >= LAT_PH) ? SEL_BYPASS : SEL_DELAY;
    word_mark = en && locked_q && (phase == LAT_PH);
    locked    = locked_q;
  end

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && start) |=> (cnt_q == PW'(1)));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(cnt_q) && $stable(locked_q)));

  // R7
  lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_q |-> !word_mark);

endmodule

// File: rtl/rot_delay_line.sv
module rot_delay_line #(
  parameter int DEPTH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  output logic dout
);

  logic [DEPTH-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (en) sr_d = {sr_q[DEPTH-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign dout = sr_q[DEPTH-1];

  // R3
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (sr_q[0] == $past(din)));

endmodule

// File: rtl/serial_rotl_fixed.sv
module serial_rotl_fixed
  import serial_rot_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ROT    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_start,
  input  logic in_bit,
  output logic out_bit,
  output logic out_start
);

  rot_sel_e sel;
  logic     tap;
  logic     mark;
  logic     locked;

  rot_phase_ctr #(.WORD_W(WORD_W), .ROT(ROT)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (in_valid),
    .start     (in_start),
    .sel       (sel),
    .word_mark (mark),
    .locked    (locked)
  );

  rot_delay_line #(.DEPTH(WORD_W)) u_delay (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (in_valid),
    .din   (in_bit),
    .dout  (tap)
  );

  always_comb begin
    out_bit   = (sel == SEL_BYPASS) ? in_bit : tap;
    out_start = mark;
  end

  // R1
  mark_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |-> (sel == SEL_BYPASS));

  // R5
  idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !out_start);

  // R7
  unlocked_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !out_start);

endmodule

// File: tb/serial_rotl_fixed_test.sv
module serial_rotl_fixed_test;

  localparam int W    = 32;
  localparam int R    = 3;
  localparam int LAT  = W - R;
  localparam int MAXV = 4096;
  localparam int MAXW = 128;

  logic clk = 1'b0;
  logic rst_n, in_valid, in_start, in_bit;
  logic out_bit, out_start;

  always #10 clk = ~clk;

  serial_rotl_fixed #(.WORD_W(W), .ROT(R)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
    .in_bit(in_bit), .out_bit(out_bit), .out_start(out_start)
  );

  int errors = 0;
  int checks = 0;

  logic vb[MAXV], vs[MAXV], ob[MAXV], os[MAXV], eos[MAXV];
  int   stall[MAXV];
  int   nv = 0;
  int   wst[MAXW];
  logic [W-1:0] wv[MAXW];
  int   nw = 0;
  int   trunc_idx, rand_first, walk_first;

  function automatic logic [W-1:0] rotl(input logic [W-1:0] w);
    return {w[W-R-1:0], w[W-1:W-R]};
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_bit(input logic b, input logic s, input int st);
    vb[nv] = b; vs[nv] = s; stall[nv] = st; nv++;
  endtask

  task automatic put_word(input logic [W-1:0] w, input int pct, input int len);
    wst[nw] = nv; wv[nw] = w; nw++;
    for (int i = 0; i < len; i++)
      put_bit(w[i], i == 0,
              (pct > 0 && $urandom_range(99) < pct) ? $urandom_range(3, 1) : 0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_start = 1'b0; in_bit = 1'b0;
    repeat (3) @(negedge clk);
    #5 check(out_start == 1'b0, "R7 reset", 64'(out_start), 64'd0);

    // stimulus: junk, walking ones, fixed patterns, a cut word, random with gaps
    for (int i = 0; i < 5; i++) put_bit(1'b1, 1'b0, 0);
    walk_first = nw;
    for (int k = 0; k < W; k++) put_word(W'(1) << k, 0, W);
    put_word('0, 0, W);
    put_word('1, 0, W);
    trunc_idx = nw;
    put_word(W'($urandom), 0, 10);
    rand_first = nw;
    for (int j = 0; j < 64; j++) put_word(W'($urandom), 25, W);
    for (int i = 0; i < LAT; i++) put_bit(1'b0, 1'b0, 0);

    @(negedge clk) rst_n = 1'b1;

    for (int vi = 0; vi < nv; vi++) begin
      for (int s = 0; s < stall[vi]; s++) begin
        @(negedge clk);
        in_valid = 1'b0; in_start = 1'b1; in_bit = 1'($urandom);
        #5 check(out_start == 1'b0, "R5 idle", 64'(out_start), 64'd0);
      end
      @(negedge clk);
      in_valid = 1'b1; in_start = vs[vi]; in_bit = vb[vi];
      #5;
      ob[vi] = out_bit;
      os[vi] = out_start;
    end
    @(negedge clk);
    in_valid = 1'b0; in_start = 1'b0;

    // expected start markers
    for (int vi = 0; vi < nv; vi++) eos[vi] = 1'b0;
    for (int j = 0; j < nw; j++) begin
      int nxt;
      nxt = (j + 1 < nw) ? wst[j+1] : MAXV;
      if (nxt - wst[j] > LAT && wst[j] + LAT < nv) eos[wst[j] + LAT] = 1'b1;
    end
    for (int vi = 0; vi < nv; vi++)
      check(os[vi] == eos[vi], (vi < wst[0]) ? "R7 unaligned" : "R1 marker",
            64'(os[vi]), 64'(eos[vi]));

    // R6: cut-short word gives no marker, next word does
    check(os[wst[trunc_idx] + LAT] == 1'b0, "R6 cut word",
          64'(os[wst[trunc_idx] + LAT]), 64'd0);
    check(os[wst[rand_first] + LAT] == 1'b1, "R6 realigned",
          64'(os[wst[rand_first] + LAT]), 64'd1);

    // R4: one marker per contiguous walking word
    begin
      int cnt;
      cnt = 0;
      for (int vi = wst[walk_first] + LAT; vi < wst[walk_first + W] + LAT; vi++)
        if (os[vi]) cnt++;
      check(cnt == W, "R4 marker count", 64'(cnt), 64'(W));
    end

    // rotated words
    for (int j = 0; j < nw; j++) begin
      int nxt, s;
      logic [W-1:0] got, exp;
      s   = wst[j];
      nxt = (j + 1 < nw) ? wst[j+1] : MAXV;
      if (nxt - s >= W && s + LAT + W <= nv) begin
        for (int k = 0; k < W; k++) got[k] = ob[s + LAT + k];
        exp = rotl(wv[j]);
        check(got[R-1:0] == exp[R-1:0],
              (j >= rand_first) ? "R2 low bits with gaps (R5)" : "R2 low bits R4",
              64'(got), 64'(exp));
        check(got[W-1:R] == exp[W-1:R],
              (j >= rand_first) ? "R3 high bits with gaps (R5)" : "R3 high bits R4",
              64'(got), 64'(exp));
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule